// File: doc/BRIEF.md
# DRAM Supply-Current Stimulus Generator

This block drives the repeating pin activity that a DDR3 memory device sees while its supply current is measured. It runs on a single clock. Every clock it produces chip-select, row-strobe, column-strobe and write-enable levels, row/column address bits, bank address bits, data bits and a data mask. The pattern follows a fixed toggling rule. Address and bank bits hold for four clocks and then invert. Data bits invert on every clock. The mask is held low.

The command pins normally repeat a four-clock background of two deselect-style encodings. A test sequencer can place a real command, such as an activate or a read, on the command pins for a single cycle. It does this by raising an insertion valid bit with the wanted levels. A run enable pauses the whole pattern, so a bench or sequencer can stall it without losing its position.

Top module: `dram_idd_stim`

## Requirements
- R1: While `run_en` is high, every address output bit holds its level for four consecutive enabled clocks. All address bits then invert together on the same edge, which is the edge where the 2-bit phase wraps from 3 to 0. After reset the address is all zero for phases 0 to 3.
- R2: The bank address outputs follow the same hold-four-then-invert rule as the address, and they invert on the same edge. Every bank bit always equals every address bit.
- R3: With no insertion, the command pins {cs_n, ras_n, cas_n, we_n} read {1,0,0,0} in phases 0 and 1 and {1,1,1,1} in phases 2 and 3. The phase counts enabled clocks since reset, modulo 4.
- R4: When `ins_valid` and `run_en` are both high, the command pins show `ins_cmd` in that same cycle, with bit 3 on cs_n, bit 2 on ras_n, bit 1 on cas_n and bit 0 on we_n. The background returns in the next cycle in which `ins_valid` is low.
- R5: While `run_en` is high, every data output bit inverts on every clock, so each level lasts one full clock. All data bits are equal.
- R6: The mask output `dm` is low in every cycle, including during reset.
- R7: While `run_en` is low, the phase, address, bank and data outputs keep their values. An insertion request is ignored, and the command pins show the background for the held phase.
- R8: A clock edge with `rst_n` low clears the address, bank, data and phase, whatever `run_en` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Advances the pattern when high, freezes it when low |
| ins_valid | input | 1 | Requests a real command in this cycle |
| ins_cmd | input | 4 | Inserted levels {cs_n, ras_n, cas_n, we_n} |
| cs_n | output | 1 | Chip-select level |
| ras_n | output | 1 | Row-strobe level |
| cas_n | output | 1 | Column-strobe level |
| we_n | output | 1 | Write-enable level |
| addr | output | ADDR_W | Row/column address bits |
| ba | output | BANK_W | Bank address bits |
| dq | output | DQ_W | Data bits |
| dm | output | DM_W | Data mask bits |

## Verification
The bench builds the block with ADDR_W=6, BANK_W=2, DQ_W=8 and DM_W=1, and keeps the hold length at four clocks. These narrow buses still show that all bits move together, and they keep each check to a single comparison. The four-clock hold lets a dozen table vectors cover a full address wrap and a pause in the middle of a phase. The same vectors also place insertions at both background encodings. A free-running stretch then runs for several address periods after a reset given in mid-run.

// File: rtl/dram_idd_stim_pkg.sv
// Shared constants for the supply-current stimulus generator.
// Assumes command levels are packed {cs_n, ras_n, cas_n, we_n}, MSB first.
package dram_idd_stim_pkg;
    typedef logic [3:0] cmd_lvl_t;
    localparam cmd_lvl_t BG_LOW_HALF  = 4'b1000;
    localparam cmd_lvl_t BG_HIGH_HALF = 4'b1111;
endpackage

// File: rtl/idd_phase_ctr.sv
// Free-running phase counter shared by all toggling outputs.
// Assumes the hold length is a power of two (2**HOLD_LOG2 clocks).
// Raises wrap in the cycle where the next enabled edge returns it to zero.
module idd_phase_ctr #(
    parameter int HOLD_LOG2 = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    output logic                 wrap,
    output logic                 half_msb
);
    logic [HOLD_LOG2-1:0] phase_q;

    // Count enabled clocks; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (run_en)
            phase_q <= phase_q + 1'b1;
    end

    assign wrap     = &phase_q;
    assign half_msb = phase_q[HOLD_LOG2-1];

    // R7: the phase does not move while paused
    a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(phase_q));
    // R8: reset returns the phase to zero
    a_r8_phase_clear: assert property (@(posedge clk)
        !rst_n |=> phase_q == '0);
endmodule

// File: rtl/idd_level_toggler.sv
// A bank of output levels that all invert together when flip is requested.
// Assumes all bits start low out of reset and stay equal to each other.
module idd_level_toggler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         flip,
    output logic [W-1:0] lvl
);
    logic [W-1:0] lvl_q;

    // Invert every bit on an enabled flip request; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= '0;
        else if (run_en && flip)
            lvl_q <= ~lvl_q;
    end

    assign lvl = lvl_q;

    // R1/R5: a requested flip inverts the whole vector
    a_r1_flip_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && flip |=> lvl_q == ~$past(lvl_q));
    // R7: without an enabled flip the levels stay put
    a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && flip) |=> $stable(lvl_q));
endmodule

// File: rtl/idd_cmd_select.sv
// Chooses between the background command and an inserted command.
// Assumes the background is split into two equal halves of the phase.
// An insertion is honoured only while the pattern is running.
module idd_cmd_select
    import dram_idd_stim_pkg::*;
(
    input  logic     run_en,
    input  logic     half_msb,
    input  logic     ins_valid,
    input  cmd_lvl_t ins_cmd,
    output cmd_lvl_t cmd
);
    cmd_lvl_t bg_cmd;

    // Pick the background encoding for the current half of the phase.
    always_comb begin
        bg_cmd = half_msb ? BG_HIGH_HALF : BG_LOW_HALF;
    end

    // Splice the inserted command over the background for one cycle.
    always_comb begin
        cmd = (run_en && ins_valid) ? ins_cmd : bg_cmd;
    end
endmodule

// File: rtl/dram_idd_stim.sv
// Top of the supply-current stimulus generator.
// Assumes one clock domain and a synchronous active-low reset.
// Address and bank share one wrap pulse, so every bit inverts on the same edge.
module dram_idd_stim
    import dram_idd_stim_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int BANK_W    = 3,
    parameter int DQ_W      = 64,
    parameter int DM_W      = 8,
    parameter int HOLD_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ins_valid,
    input  logic [3:0]        ins_cmd,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic [DQ_W-1:0]   dq,
    output logic [DM_W-1:0]   dm
);
    localparam int ADDR_BA_W = ADDR_W + BANK_W;

    logic                 wrap;
    logic                 half_msb;
    logic [ADDR_BA_W-1:0] addr_ba;
    cmd_lvl_t             cmd;

    idd_phase_ctr #(.HOLD_LOG2(HOLD_LOG2)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .wrap     (wrap),
        .half_msb (half_msb)
    );

    idd_level_toggler #(.W(ADDR_BA_W)) addr_tog_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .flip   (wrap),
        .lvl    (addr_ba)
    );

    idd_level_toggler #(.W(DQ_W)) dq_tog_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .flip   (1'b1),
        .lvl    (dq)
    );

    idd_cmd_select cmd_i (
        .run_en    (run_en),
        .half_msb  (half_msb),
        .ins_valid (ins_valid),
        .ins_cmd   (ins_cmd),
        .cmd       (cmd)
    );

    // Split the shared toggler into address and bank pins.
    always_comb begin
        addr = addr_ba[ADDR_W-1:0];
        ba   = addr_ba[ADDR_BA_W-1:ADDR_W];
    end

    // Unpack the command levels onto their pins.
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = cmd;
    end

    assign dm = '0;

    // R2: bank bits always match the address bits
    a_r2_bank_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        ba == {BANK_W{addr[0]}});
    // R3: right after an address flip the phase is back in the low half
    a_r3_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) && !(run_en && ins_valid)
        |-> {cs_n, ras_n, cas_n, we_n} == BG_LOW_HALF);
    // R5: data inverts on every running edge
    a_r5_dq_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> dq == ~$past(dq));
    // R8: reset clears address and data pins
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (addr == '0) && (dq == '0) && (ba == '0));
endmodule

// File: tb/dram_idd_stim_tb_top.sv
// Self-checking bench: table of vectors, then directed reset and long-run tests.
module dram_idd_stim_tb_top;
    localparam int ADDR_W = 6;
    localparam int BANK_W = 2;
    localparam int DQ_W   = 8;
    localparam int DM_W   = 1;
    localparam int NVEC   = 12;

    // {run, ins_valid, ins_cmd[3:0], exp_cmd[3:0], exp_addr_lvl, exp_dq_lvl}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b1_0_0000_1000_0_0,
        12'b1_0_0000_1000_0_1,
        12'b1_0_0000_1111_0_0,
        12'b1_1_0011_0011_0_1,
        12'b1_0_0000_1000_1_0,
        12'b0_1_0101_1000_1_1,
        12'b0_0_0000_1000_1_1,
        12'b1_1_0101_0101_1_1,
        12'b1_0_0000_1111_1_0,
        12'b1_0_0000_1111_1_1,
        12'b1_0_0000_1000_0_0,
        12'b1_1_1111_1111_0_1
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic              ins_valid = 1'b0;
    logic [3:0]        ins_cmd = 4'b0000;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] ba;
    logic [DQ_W-1:0]   dq;
    logic [DM_W-1:0]   dm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dram_idd_stim #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DQ_W(DQ_W), .DM_W(DM_W), .HOLD_LOG2(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ins_valid(ins_valid),
        .ins_cmd(ins_cmd), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .dq(dq), .dm(dm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tg, input logic [3:0] ecmd, input logic ea, input logic ed);
        chk({tg, " R3 R4 R7 cmd"}, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, ecmd});
        chk({tg, " R1 addr"}, {26'd0, addr}, {26'd0, {ADDR_W{ea}}});
        chk({tg, " R2 bank"}, {30'd0, ba}, {30'd0, {BANK_W{ea}}});
        chk({tg, " R5 dq"}, {24'd0, dq}, {24'd0, {DQ_W{ed}}});
        chk({tg, " R6 dm"}, {31'd0, dm}, 32'd0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic       m_a, m_d;
        logic [1:0] m_ph;
        // R8: reset state, with run high during reset
        run_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1 chk_all("reset R8", 4'b1000, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Table walk: one vector per clock
        for (int i = 0; i < NVEC; i++) begin
            run_en    = VEC[i][11];
            ins_valid = VEC[i][10];
            ins_cmd   = VEC[i][9:6];
            #1 chk_all($sformatf("vec%0d", i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
            @(negedge clk);
        end

        // R8: mid-run reset clears state even with run high
        run_en = 1'b1; ins_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1 chk_all("midrun R8", 4'b1000, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Long run against a bench model; an insertion every seventh cycle
        m_ph = 2'd0; m_a = 1'b0; m_d = 1'b0;
        for (int k = 0; k < 40; k++) begin
            logic [3:0] ecmd;
            ins_valid = (k % 7 == 3);
            ins_cmd   = 4'(k);
            ecmd = ins_valid ? 4'(k) : (m_ph[1] ? 4'b1111 : 4'b1000);
            #1 chk_all($sformatf("run%0d", k), ecmd, m_a, m_d);
            @(negedge clk);
            if (m_ph == 2'd3) m_a = ~m_a;
            m_ph = m_ph + 2'd1;
            m_d  = ~m_d;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule